// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Page-Mode Line Fill

This block sits between a 32-bit processor request port and a memory port whose accesses come in two kinds: a full random access that opens a new row, and a cheaper sequential access that stays in the open row. It holds 4 KB of data as 256 lines of four 32-bit words each. Every line has one tag and one valid bit, and there is one possible line for each address.

A read that finds its line is answered from the cache in the same cycle, and memory sees no request. A read that misses fetches the whole 16-byte line. The first word goes out as a random access and the other three go out as sequential accesses. The requested word is returned once the last beat has landed. Every write goes straight to memory as a single random access. If the line is present, the cached word is updated as well. If it is not, no line is allocated.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first read of any address causes a line fill.
- R2: A read whose line is valid with a matching tag raises `cpu_ready` in the cycle the request is presented, carries the stored word on `cpu_rdata`, and leaves `mem_req` low.
- R3: A read miss issues exactly four memory reads to line base +0, +4, +8 and +12, in that order. The first is marked random (`mem_seq`=0) and the other three sequential (`mem_seq`=1).
- R4: On a read miss, `cpu_ready` rises only after the fourth fill beat is acknowledged. It rises in the cycle after that acknowledge, with the word at the requested word offset (address bits 3:2), whatever that offset is.
- R5: A write issues exactly one memory access with `mem_we`=1 and `mem_seq`=0, at the word address (bits 1:0 cleared) with `cpu_wdata`. `cpu_ready` is high in the cycle `mem_ack` is high.
- R6: A write whose line is present updates the cached word. The next read of that address hits and returns the new value.
- R7: A write whose line is absent allocates nothing. The next read of that address misses and fills.
- R8: The line index is address bits 11:4 and the tag is bits 31:12. A read that maps to the same index with a different tag replaces the line, so the earlier address misses again afterwards.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_seq` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Request complete in this cycle |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_seq | output | 1 | 1 = sequential access in the open row, 0 = random access |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete in this cycle |

## Verification
A valid bit that is wrong or stale shows up at the very next read of that index. Either memory traffic appears where a hit was due, or `cpu_ready` arrives at once with a word memory never supplied. A wrong beat counter or a wrong write-enable during fill leaves a corrupted word in the line. That word is visible at the first later hit on that offset, which the bench reaches within a few requests. A wrong sequential flag or beat address is visible on the memory port during the fill itself.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_tags.sv
module wtc_tags #(
  parameter int LINES = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (set_en) valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

  // a freshly installed line answers a lookup of the same index and tag
  p_install_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && look_idx == set_idx && look_tag == set_tag
    |=> ($stable(look_idx) && $stable(look_tag)) -> look_hit);
endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_wsel,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [LINES*LINE_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_wsel}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_wsel}];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              hit,
  input  logic              mem_ack,
  output wtc_state_e        state,
  output logic [WSEL_W-1:0] beat,
  output logic              fill_beat_ack,
  output logic              fill_last,
  output logic              write_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_seq,
  output logic              cpu_ready
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  wtc_state_e        state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;

  assign state         = state_q;
  assign beat          = beat_q;
  assign fill_beat_ack = (state_q == ST_FILL) && mem_ack;
  assign fill_last     = fill_beat_ack && (beat_q == LAST_BEAT);
  assign write_done    = (state_q == ST_WRITE) && mem_ack;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (cpu_req && cpu_we)    state_d = ST_WRITE;
        else if (cpu_req && !hit) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (fill_beat_ack) beat_d = beat_q + 1'b1;
        if (fill_last)     state_d = ST_IDLE;
      end
      ST_WRITE: if (write_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_seq   = (state_q == ST_FILL) && (beat_q != '0);
  assign cpu_ready = ((state_q == ST_IDLE) && cpu_req && !cpu_we && hit) || write_done;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_seq));

  p_write_random_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_seq);

  p_fill_opens_random_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> !mem_seq);
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_seq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  import wtc_pkg::*;

  localparam int BYTE_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTE_W);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W;

  function automatic logic [IDX_W-1:0] f_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W+WSEL_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_beat_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [WSEL_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = a;
    r[OFF_W +: WSEL_W] = b;
    r[OFF_W-1:0] = '0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] f_word_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[OFF_W-1:0] = '0;
    return r;
  endfunction

  wtc_state_e        state;
  logic [WSEL_W-1:0] beat;
  logic              hit, fill_beat_ack, fill_last, write_done;
  logic              data_wr_en;
  logic [WSEL_W-1:0] data_wr_wsel;
  logic [DATA_W-1:0] data_wr_val;

  wtc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_idx (f_index(cpu_addr)),
    .look_tag (f_tag(cpu_addr)),
    .look_hit (hit),
    .set_en   (fill_last),
    .set_idx  (f_index(cpu_addr)),
    .set_tag  (f_tag(cpu_addr))
  );

  assign data_wr_en   = fill_beat_ack || (write_done && hit);
  assign data_wr_wsel = fill_beat_ack ? beat : f_wsel(cpu_addr);
  assign data_wr_val  = fill_beat_ack ? mem_rdata : cpu_wdata;

  wtc_data #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (f_index(cpu_addr)),
    .rd_wsel (f_wsel(cpu_addr)),
    .rd_data (cpu_rdata),
    .wr_en   (data_wr_en),
    .wr_idx  (f_index(cpu_addr)),
    .wr_wsel (data_wr_wsel),
    .wr_data (data_wr_val)
  );

  wtc_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .hit           (hit),
    .mem_ack       (mem_ack),
    .state         (state),
    .beat          (beat),
    .fill_beat_ack (fill_beat_ack),
    .fill_last     (fill_last),
    .write_done    (write_done),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_seq       (mem_seq),
    .cpu_ready     (cpu_ready)
  );

  assign mem_addr  = (state == ST_WRITE) ? f_word_addr(cpu_addr) : f_beat_addr(cpu_addr, beat);
  assign mem_wdata = cpu_wdata;

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cpu_we |-> !mem_req);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));

  p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we && !fill_last
    |=> mem_req && mem_seq && mem_addr == $past(mem_addr) + ADDR_W'(BYTE_W));

  p_fill_then_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last && cpu_req |=> cpu_ready);

  p_write_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> mem_ack && mem_we);
endmodule

// File: tb/wt_cache_bench.sv
module wt_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we, mem_seq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  wt_cache u_wt_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_seq(mem_seq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] bmem [4096];
  int          log_n;
  logic [31:0] log_addr [8];
  logic [31:0] log_wd [8];
  logic        log_seq [8];
  logic        log_we [8];
  int          hold_err = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: random access waits two cycles, sequential none
  initial begin
    int wcnt;
    wcnt = 0;
    for (int i = 0; i < 4096; i++) bmem[i] = (i * 32'h9E3779B9) ^ 32'h5A5A0000;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (rst_n && mem_req) begin
        if (wcnt >= (mem_seq ? 0 : 2)) begin
          if (log_n < 8) begin
            log_addr[log_n] = mem_addr;
            log_wd[log_n]   = mem_wdata;
            log_seq[log_n]  = mem_seq;
            log_we[log_n]   = mem_we;
          end
          log_n++;
          if (mem_we) bmem[mem_addr[13:2]] = mem_wdata;
          else mem_rdata = bmem[mem_addr[13:2]];
          mem_ack = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  // request hold monitor
  initial begin
    logic pend;
    logic [31:0] pa;
    pend = 0;
    pa = '0;
    forever begin
      @(negedge clk); #3;
      if (pend && !(mem_req && mem_addr == pa)) hold_err++;
      pend = rst_n && mem_req && !mem_ack;
      pa = mem_addr;
    end
  end

  task automatic do_read(input logic [31:0] a, input bit exp_miss, input string rq);
    int cyc;
    logic [31:0] exp;
    log_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #2;
    cyc = 0;
    while (!cpu_ready && cyc < 200) begin @(negedge clk); #2; cyc++; end
    exp = bmem[a[13:2]];
    chk(cpu_ready, {rq, " ready"}, 32'(cpu_ready), 32'd1);
    chk(cpu_rdata == exp, {rq, " data"}, cpu_rdata, exp);
    if (exp_miss) begin
      chk(log_n == 4, {rq, " R4 beats before ready"}, 32'(log_n), 32'd4);
      for (int b = 0; b < 4; b++) begin
        chk(log_addr[b] == {a[31:4], 4'(b * 4)}, {rq, " R3 beat addr"}, log_addr[b], {a[31:4], 4'(b * 4)});
        chk(log_seq[b] == (b != 0) && !log_we[b], {rq, " R3 beat kind"}, 32'(log_seq[b]), 32'(b != 0));
      end
    end else begin
      chk(cyc == 0, {rq, " R2 same cycle"}, 32'(cyc), 32'd0);
      chk(log_n == 0, {rq, " R2 no memory"}, 32'(log_n), 32'd0);
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int cyc;
    log_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #2;
    cyc = 0;
    while (!cpu_ready && cyc < 200) begin @(negedge clk); #2; cyc++; end
    chk(cpu_ready && mem_ack, "R5 ready with ack", 32'(cpu_ready), 32'd1);
    chk(log_n == 1, "R5 single access", 32'(log_n), 32'd1);
    chk(log_we[0] && !log_seq[0], "R5 random write", {30'd0, log_we[0], log_seq[0]}, 32'd2);
    chk(log_addr[0] == {a[31:2], 2'b00}, "R5 address", log_addr[0], {a[31:2], 2'b00});
    chk(log_wd[0] == d, "R5 data", log_wd[0], d);
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic sc_reset;
    chk(!cpu_ready && !mem_req, "R1 reset outputs", {30'd0, cpu_ready, mem_req}, 32'd0);
  endtask

  task automatic sc_cold_and_hit;
    do_read(32'h0000_0108, 1, "R1 cold miss");
    do_read(32'h0000_0104, 0, "R2 hit");
    do_read(32'h0000_010C, 0, "R2 hit");
    do_read(32'h0000_0100, 0, "R2 hit");
  endtask

  task automatic sc_write_hit;
    do_write(32'h0000_0104, 32'hCAFE_0001);
    do_read(32'h0000_0104, 0, "R6 write hit readback");
    chk(cpu_rdata == 32'hCAFE_0001, "R6 value", cpu_rdata, 32'hCAFE_0001);
  endtask

  task automatic sc_write_miss;
    do_write(32'h0000_2208, 32'hBEEF_0002);
    do_read(32'h0000_2208, 1, "R7 no allocate");
  endtask

  task automatic sc_conflict;
    do_read(32'h0000_1100, 1, "R8 conflict fill");
    do_read(32'h0000_0104, 1, "R8 evicted line");
    do_read(32'h0000_1100, 1, "R8 evicted again");
  endtask

  task automatic sc_offsets;
    do_read(32'h0000_3F0C, 1, "R4 last word");
    do_read(32'h0000_3F00, 0, "R2 first word hit");
    do_read(32'h0000_0A80, 1, "R4 first word");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    log_n = 0;
    repeat (3) @(posedge clk);
    #1;
    sc_reset();
    rst_n = 1'b1;
    sc_cold_and_hit();
    sc_write_hit();
    sc_write_miss();
    sc_conflict();
    sc_offsets();
    chk(hold_err == 0, "R9 request hold", 32'(hold_err), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule